// File: doc/BRIEF.md
# Split-Carry Pipelined Subword Adder

This block is a two-stage integer adder for a SIMD arithmetic cluster. The carry chain is split across the two pipeline stages. The first stage adds the lower half of the two operands. It registers that partial sum and the carry leaving it, and it holds the upper halves of both operands in registers of their own. The second stage adds the upper halves together with that carry, then places the upper sum above the lower sum to form the result. The adder accepts a new operation on every clock.

A mode bit travels with each operation and selects one of two kinds of add. The first is one full-width add. The second is a set of independent 8-bit lane adds, where no carry crosses a lane boundary and each lane reports its own carry-out. A synchronous clear empties the pipeline. The width is a parameter and must be a multiple of twice the lane width. The default is 16 bits, which gives two halves of one lane each.

Top module: `split_carry_adder`

## Requirements
- R1: When `rst` or `clr` is high at a rising edge, every pipeline register is zeroed. The outputs then show `out_valid`=0, `out_sum`=0, `out_carry`=0 and `out_lane_carry`=0 for that cycle and for the next one.
- R2: `out_valid` equals the `in_valid` presented two rising edges earlier, provided no clear intervened.
- R3: With `in_mode`=0 (full mode), `out_sum` is (a+b) mod 2^WIDTH and `out_carry` is bit WIDTH of a+b.
- R4: In full mode, the carry out of the lower half (bit WIDTH/2-1) reaches the upper-half add one stage later. For example, 0x00FF+0x0001 gives 0x0100.
- R5: With `in_mode`=1 (lane mode), each 8-bit lane i occupies bits [8i+7:8i]. Its sum is (a_i+b_i) mod 256, and no carry enters from lane i-1.
- R6: In lane mode, bit i of `out_lane_carry` is the carry-out of lane i and `out_carry` is 0. In full mode, `out_lane_carry` is all zero.
- R7: A new operation is accepted on every cycle. Back-to-back operations with no idle cycles each produce their own result two cycles later.
- R8: The mode is sampled per operation and travels with it, so consecutive operations may alternate modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous pipeline clear |
| in_valid | input | 1 | Operation present on the operand inputs |
| in_mode | input | 1 | 0 = full-width add, 1 = independent 8-bit lanes |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| out_valid | output | 1 | Result valid, two cycles after the operation |
| out_sum | output | WIDTH | Sum, upper half above lower half |
| out_carry | output | 1 | Full-width carry-out (0 in lane mode) |
| out_lane_carry | output | WIDTH/8 | Per-lane carry-outs (0 in full mode) |

## Verification
Every result, including sum, carries and valid, is due at the second rising edge after the operation is driven. A clear wipes out the result due at the next edge and the one due at the edge after that. The bench drives inputs on the falling edge. It keeps a two-deep queue of expected results computed from the requirements, and at each falling edge it compares the outputs with the entry driven two falling edges before. When a clear is driven, the bench zeroes both the pending entry and the new one. Directed cases exercise the carry that crosses the halves and lane carries that wrap to zero. Seeded random traffic then mixes modes, idle slots and clears.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
  typedef enum logic {
    ADD_FULL  = 1'b0,
    ADD_LANES = 1'b1
  } add_mode_e;
endpackage

// File: rtl/sadd_lane_chain.sv
// Combinational chain of lane adders; carries between lanes are cut when requested.
module sadd_lane_chain #(
  parameter int LANE_W  = 8,
  parameter int N_LANES = 1
) (
  input  logic [N_LANES*LANE_W-1:0] a,
  input  logic [N_LANES*LANE_W-1:0] b,
  input  logic                      cin,
  input  logic                      cut,
  output logic [N_LANES*LANE_W-1:0] sum,
  output logic [N_LANES-1:0]        lane_cout
);
  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    logic ci;
    if (i == 0) begin : g_first
      assign ci = cin;
    end else begin : g_next
      assign ci = cut ? 1'b0 : lane_cout[i-1];
    end
    assign {lane_cout[i], sum[i*LANE_W +: LANE_W]} =
      {1'b0, a[i*LANE_W +: LANE_W]} + {1'b0, b[i*LANE_W +: LANE_W]} + (LANE_W+1)'(ci);
  end
endmodule

// File: rtl/sadd_lo_stage.sv
// Stage one: adds the lower halves, registers the partial sum, the carry and the upper halves.
module sadd_lo_stage
  import sadd_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int LANE_W = 8,
  localparam int HALF  = WIDTH / 2,
  localparam int NL_H  = HALF / LANE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            in_valid,
  input  add_mode_e       in_mode,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic            s1_valid,
  output add_mode_e       s1_mode,
  output logic [HALF-1:0] s1_lo_sum,
  output logic [NL_H-1:0] s1_lo_lc,
  output logic            s1_mid_c,
  output logic [HALF-1:0] s1_a_hi,
  output logic [HALF-1:0] s1_b_hi
);
  logic [HALF-1:0] lo_sum;
  logic [NL_H-1:0] lo_lc;
  logic            lanes;

  assign lanes = (in_mode == ADD_LANES);

  sadd_lane_chain #(.LANE_W(LANE_W), .N_LANES(NL_H)) u_lo (
    .a(in_a[HALF-1:0]), .b(in_b[HALF-1:0]), .cin(1'b0), .cut(lanes),
    .sum(lo_sum), .lane_cout(lo_lc)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      s1_valid  <= 1'b0;
      s1_mode   <= ADD_FULL;
      s1_lo_sum <= '0;
      s1_lo_lc  <= '0;
      s1_mid_c  <= 1'b0;
      s1_a_hi   <= '0;
      s1_b_hi   <= '0;
    end else begin
      s1_valid  <= in_valid;
      s1_mode   <= in_mode;
      s1_lo_sum <= lo_sum;
      s1_lo_lc  <= lo_lc;
      s1_mid_c  <= lanes ? 1'b0 : lo_lc[NL_H-1];
      s1_a_hi   <= in_a[WIDTH-1:HALF];
      s1_b_hi   <= in_b[WIDTH-1:HALF];
    end
  end

  AST_MID_CARRY_CUT: assert property (@(posedge clk) disable iff (rst)
    (!clr && in_mode == ADD_LANES) |=> !s1_mid_c); // R5
  AST_S1_VALID_FWD: assert property (@(posedge clk) disable iff (rst)
    (!clr && in_valid) |=> s1_valid); // R2
  AST_S1_MODE_FWD: assert property (@(posedge clk) disable iff (rst)
    (!clr && in_mode == ADD_LANES) |=> s1_mode == ADD_LANES); // R8
endmodule

// File: rtl/sadd_hi_stage.sv
// Stage two: adds the upper halves with the carry from stage one and joins the halves.
module sadd_hi_stage
  import sadd_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int LANE_W = 8,
  localparam int HALF  = WIDTH / 2,
  localparam int NL_H  = HALF / LANE_W,
  localparam int NL    = WIDTH / LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             s1_valid,
  input  add_mode_e        s1_mode,
  input  logic [HALF-1:0]  s1_lo_sum,
  input  logic [NL_H-1:0]  s1_lo_lc,
  input  logic             s1_mid_c,
  input  logic [HALF-1:0]  s1_a_hi,
  input  logic [HALF-1:0]  s1_b_hi,
  output logic             o_valid,
  output logic [WIDTH-1:0] o_sum,
  output logic             o_carry,
  output logic [NL-1:0]    o_lane_carry
);
  logic [HALF-1:0] hi_sum;
  logic [NL_H-1:0] hi_lc;
  logic            lanes;

  assign lanes = (s1_mode == ADD_LANES);

  sadd_lane_chain #(.LANE_W(LANE_W), .N_LANES(NL_H)) u_hi (
    .a(s1_a_hi), .b(s1_b_hi), .cin(s1_mid_c), .cut(lanes),
    .sum(hi_sum), .lane_cout(hi_lc)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      o_valid      <= 1'b0;
      o_sum        <= '0;
      o_carry      <= 1'b0;
      o_lane_carry <= '0;
    end else begin
      o_valid      <= s1_valid;
      o_sum        <= {hi_sum, s1_lo_sum};
      o_carry      <= lanes ? 1'b0 : hi_lc[NL_H-1];
      o_lane_carry <= lanes ? {hi_lc, s1_lo_lc} : '0;
    end
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!o_valid && o_sum == '0 && !o_carry && o_lane_carry == '0)); // R1
  AST_VALID_FWD: assert property (@(posedge clk) disable iff (rst)
    (!clr && s1_valid) |=> o_valid); // R2
  AST_LANE_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (!clr && s1_mode == ADD_LANES) |=> !o_carry); // R6
  AST_FULL_NO_LANE_C: assert property (@(posedge clk) disable iff (rst)
    (!clr && s1_mode == ADD_FULL) |=> o_lane_carry == '0); // R6
endmodule

// File: rtl/split_carry_adder.sv
// Two-stage split-carry adder with full-width and 8-bit lane modes.
// WIDTH must be a multiple of 2*LANE_W.
module split_carry_adder
  import sadd_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int LANE_W = 8,
  localparam int HALF  = WIDTH / 2,
  localparam int NL_H  = HALF / LANE_W,
  localparam int NL    = WIDTH / LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             in_valid,
  input  logic             in_mode,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_sum,
  output logic             out_carry,
  output logic [NL-1:0]    out_lane_carry
);
  logic            s1_valid;
  add_mode_e       s1_mode;
  logic [HALF-1:0] s1_lo_sum;
  logic [NL_H-1:0] s1_lo_lc;
  logic            s1_mid_c;
  logic [HALF-1:0] s1_a_hi;
  logic [HALF-1:0] s1_b_hi;

  sadd_lo_stage #(.WIDTH(WIDTH), .LANE_W(LANE_W)) u_lo (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
    .in_mode(add_mode_e'(in_mode)), .in_a(in_a), .in_b(in_b),
    .s1_valid(s1_valid), .s1_mode(s1_mode), .s1_lo_sum(s1_lo_sum),
    .s1_lo_lc(s1_lo_lc), .s1_mid_c(s1_mid_c), .s1_a_hi(s1_a_hi), .s1_b_hi(s1_b_hi)
  );

  sadd_hi_stage #(.WIDTH(WIDTH), .LANE_W(LANE_W)) u_hi (
    .clk(clk), .rst(rst), .clr(clr), .s1_valid(s1_valid), .s1_mode(s1_mode),
    .s1_lo_sum(s1_lo_sum), .s1_lo_lc(s1_lo_lc), .s1_mid_c(s1_mid_c),
    .s1_a_hi(s1_a_hi), .s1_b_hi(s1_b_hi),
    .o_valid(out_valid), .o_sum(out_sum), .o_carry(out_carry),
    .o_lane_carry(out_lane_carry)
  );

  AST_LANE_CARRY_ONLY_IN_LANES: assert property (@(posedge clk) disable iff (rst)
    !(out_carry && out_lane_carry != '0)); // R6
endmodule

// File: tb/sim_split_carry_adder.sv
module sim_split_carry_adder;
  localparam int W  = 16;
  localparam int L  = 8;
  localparam int NL = W / L;

  typedef struct packed {
    logic          v;
    logic [W-1:0]  s;
    logic          c;
    logic [NL-1:0] lc;
  } exp_t;

  logic clk = 1'b0;
  logic rst, clr, in_valid, in_mode;
  logic [W-1:0] in_a, in_b;
  logic out_valid, out_carry;
  logic [W-1:0] out_sum;
  logic [NL-1:0] out_lane_carry;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  exp_t  e1, e2;
  string t1, t2;

  always #5 clk = ~clk;

  split_carry_adder #(.WIDTH(W), .LANE_W(L)) u0 (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_mode(in_mode),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_sum(out_sum),
    .out_carry(out_carry), .out_lane_carry(out_lane_carry)
  );

  function automatic exp_t model(logic v, logic m, logic [W-1:0] a, logic [W-1:0] b);
    exp_t r;
    logic [W:0] t;
    logic [L:0] lt;
    r = '0;
    r.v = v;
    if (!m) begin
      t = {1'b0, a} + {1'b0, b};
      r.s = t[W-1:0];
      r.c = t[W];
    end else begin
      for (int i = 0; i < NL; i++) begin
        lt = {1'b0, a[i*L +: L]} + {1'b0, b[i*L +: L]};
        r.s[i*L +: L] = lt[L-1:0];
        r.lc[i] = lt[L];
      end
    end
    return r;
  endfunction

  task automatic compare(exp_t e, string tag);
    exp_t act;
    act = '{v: out_valid, s: out_sum, c: out_carry, lc: out_lane_carry};
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: actual v=%0b s=%h c=%0b lc=%b expected v=%0b s=%h c=%0b lc=%b",
               tag, act.v, act.s, act.c, act.lc, e.v, e.s, e.c, e.lc);
    end
  endtask

  // Drive one operation at a falling edge; check the one driven two falling edges earlier.
  task automatic step(logic v, logic m, logic [W-1:0] a, logic [W-1:0] b, logic c, string tag);
    exp_t e0;
    @(negedge clk);
    compare(e2, t2);
    if (c) e1 = '0;
    e0 = c ? exp_t'('0) : model(v, m, a, b);
    e2 = e1; t2 = t1;
    e1 = e0; t1 = tag;
    in_valid = v; in_mode = m; in_a = a; in_b = b; clr = c;
  endtask

  initial begin
    #(10 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; clr = 1'b0; in_valid = 1'b0; in_mode = 1'b0; in_a = '0; in_b = '0;
    e1 = '0; e2 = '0; t1 = "R1 reset"; t2 = "R1 reset";
    repeat (3) @(negedge clk);
    compare('0, "R1 reset state");
    rst = 1'b0;

    // directed corner cases
    step(1, 0, 16'hFFFF, 16'h0001, 0, "R3 full wrap with carry");
    step(1, 0, 16'h00FF, 16'h0001, 0, "R4 low-to-high carry");
    step(1, 1, 16'h00FF, 16'h0001, 0, "R5 lane cut");
    step(1, 1, 16'hFF80, 16'h0180, 0, "R6 both lane carries");
    step(1, 0, 16'h1234, 16'h4321, 0, "R3 plain full");
    step(1, 1, 16'h7F7F, 16'h0101, 0, "R8 mode alternates");
    step(1, 0, 16'h7F7F, 16'h0101, 0, "R8 same operands full");
    step(0, 0, 16'h0F0F, 16'h0101, 0, "R2 idle slot");
    step(1, 0, 16'h8000, 16'h8000, 0, "R6 full mode lane carry zero");
    step(1, 1, 16'hAAAA, 16'h5556, 1, "R1 clear kills op");
    step(1, 0, 16'h00FF, 16'h0101, 0, "R1 after clear");
    step(1, 1, 16'h0080, 16'h0080, 0, "R7 back to back");
    step(1, 0, 16'h0080, 16'h0080, 0, "R7 back to back");

    // seeded random traffic
    for (int k = 0; k < 400; k++) begin
      logic rv, rm, rc;
      rv = ($urandom % 4) != 0;
      rm = $urandom % 2;
      rc = ($urandom % 25) == 0;
      step(rv, rm, W'($urandom), W'($urandom), rc, rm ? "R5 R6 random lanes" : "R3 R7 random full");
    end

    step(0, 0, '0, '0, 0, "R2 drain");
    step(0, 0, '0, '0, 0, "R2 drain");
    step(0, 0, '0, '0, 0, "R2 drain");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule